// File: doc/BRIEF.md
# I2C Bus Time-out Watchdog

This block watches how long an I2C controller stays in one protocol state after software has serviced the controller's interrupt flag. A 14-bit up-counter runs on the peripheral clock while the watchdog is enabled and the interrupt-flag level is low. Whenever the flag level is high, the counter is forced to zero and held there. If the controller stalls long enough for the counter to wrap past all ones, a sticky time-out flag is raised. That flag requests an interrupt while interrupts are enabled, and software clears it with a write-one strobe.

An option input slows the count by a factor of four, which stretches the time-out period four times. Each stall produces exactly one time-out event. After the wrap, the counter stays at zero until the interrupt-flag level goes high again or the enable is cycled. Dropping the enable returns the counter and the prescaler to their idle state at once, but it does not touch a time-out flag that is already set.

Top module: `i2c_tmo_wdog`

## Requirements
- R1: With `tmo_en_i`=1, `div4_i`=0 and `sif_i`=0, the counter advances on every rising clock edge. `tmo_flag_o` rises directly after the 16384th such edge (2^14), counted from the first edge with `sif_i` low. It is still 0 after the 16383rd edge.
- R2: While `tmo_en_i`=0, `tmo_flag_o` is never set, however long `sif_i` stays low.
- R3: While `sif_i`=1, the counter is held at zero. After `sif_i` falls, a full period of 16384 counting edges is needed before a time-out, whatever count had been reached before.
- R4: With `div4_i`=1, the counter advances once per four counting edges, so `tmo_flag_o` rises directly after the 65536th counting edge.
- R5: `tmo_flag_o` stays at 1 until a clock edge samples `flag_clr_i`=1 (write one to clear). After that edge it reads 0.
- R6: `irq_o` equals `tmo_flag_o` AND `irq_en_i`, in the same cycle and without a register in between.
- R7: After a time-out, the counter stays at zero. With `sif_i` and `tmo_en_i` unchanged, no further time-out follows, even after more than one full period.
- R8: A clock edge that samples `tmo_en_i`=0 resets the counter and the prescaler. A time-out flag that is already set keeps its value.
- R9: If the hardware set of the flag and a clear strobe fall on the same clock edge, `tmo_flag_o` is 1 after that edge.
- R10: After reset, `tmo_flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sif_i | input | 1 | Interrupt-flag level of the I2C controller; high holds the counter at zero |
| tmo_en_i | input | 1 | Watchdog enable |
| div4_i | input | 1 | Divide-by-four option for the count rate |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the time-out flag |
| tmo_flag_o | output | 1 | Sticky time-out flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The time-out flag is registered, so it changes directly after the edge that completes the 16384th counting cycle (65536th with divide-by-four). A clear strobe takes effect on the next edge. The interrupt request follows the flag and its enable in the same cycle. The bench drives every input on the falling edge and compares both outputs with a behavioural model on every falling edge, so each result is read half a period after the edge that produced it. The named checks count edges from the last input change to land on the first cycle in which the flag is due, and on the cycle just before it.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  // width of the stall counter
  localparam int unsigned TMO_CNT_W    = 14;
  // log2 of the slow-mode division ratio (2 -> divide by four)
  localparam int unsigned TMO_DIV_LOG2 = 2;
endpackage

// File: rtl/i2c_tmo_presc.sv
module i2c_tmo_presc #(
  parameter int unsigned DIV_LOG2 = i2c_tmo_pkg::TMO_DIV_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic slow_i,
  output logic tick_o
);
  generate
    if (DIV_LOG2 == 0) begin : g_nodiv
      assign tick_o = arm_i;
    end else begin : g_div
      logic [DIV_LOG2-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (!arm_i || !slow_i) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign tick_o = arm_i && (!slow_i || (pre_q == {DIV_LOG2{1'b1}}));

      AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i) |=> (!tick_o || !slow_i)); // R8
    end
  endgenerate
endmodule

// File: rtl/i2c_tmo_count.sv
module i2c_tmo_count #(
  parameter int unsigned CNT_W = i2c_tmo_pkg::TMO_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             spent_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             spent_q, spent_d;
  logic             at_top;

  assign at_top = (cnt_q == {CNT_W{1'b1}});
  assign wrap_o = arm_i && !spent_q && tick_i && at_top;

  always_comb begin
    cnt_d   = cnt_q;
    spent_d = spent_q;
    if (!arm_i) begin
      cnt_d   = '0;
      spent_d = 1'b0;
    end else if (!spent_q && tick_i) begin
      cnt_d = cnt_q + 1'b1;
      if (at_top) begin
        spent_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      spent_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      spent_q <= spent_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign spent_o = spent_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0))); // R1
  AST_SPENT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    spent_q |-> (cnt_q == '0)); // R7
  AST_SPENT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (spent_q && arm_i) |=> spent_q); // R7
endmodule

// File: rtl/i2c_tmo_flag.sv
module i2c_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> flag_q); // R9
endmodule

// File: rtl/i2c_tmo_wdog.sv
module i2c_tmo_wdog #(
  parameter int unsigned CNT_W    = i2c_tmo_pkg::TMO_CNT_W,
  parameter int unsigned DIV_LOG2 = i2c_tmo_pkg::TMO_DIV_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sif_i,
  input  logic tmo_en_i,
  input  logic div4_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  output logic tmo_flag_o,
  output logic irq_o
);
  logic             base_arm;
  logic             pre_arm;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             spent;
  logic             wrap;

  assign base_arm = tmo_en_i && !sif_i;
  assign pre_arm  = base_arm && !spent;

  i2c_tmo_presc #(.DIV_LOG2(DIV_LOG2)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (pre_arm),
    .slow_i (div4_i),
    .tick_o (tick)
  );

  i2c_tmo_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (base_arm),
    .tick_i  (tick),
    .cnt_o   (cnt),
    .spent_o (spent),
    .wrap_o  (wrap)
  );

  i2c_tmo_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wrap),
    .clr_i  (flag_clr_i),
    .flag_o (tmo_flag_o)
  );

  assign irq_o = tmo_flag_o && irq_en_i;

  AST_SI_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sif_i |=> (cnt == '0)); // R3
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en_i |=> (cnt == '0)); // R8
  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_en_i && !tmo_flag_o) |=> !tmo_flag_o); // R2
  AST_DISABLED_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_en_i && tmo_flag_o && !flag_clr_i) |=> tmo_flag_o); // R8
  AST_DIV4_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((DIV_LOG2 > 0) && div4_i && $past(div4_i) && (cnt == $past(cnt) + 1'b1))
      |=> ((cnt == $past(cnt)) || (cnt == '0))); // R4
endmodule

// File: tb/i2c_tmo_wdog_tb_top.sv
module i2c_tmo_wdog_tb_top;
  localparam int CW     = 14;
  localparam int FULL   = 1 << CW;
  localparam int WD_MAX = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sif = 1'b1, en = 1'b0, div4 = 1'b0, irq_en = 1'b0, clr = 1'b0;
  logic tmo_flag, irq;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string phase = "R10";

  // behavioural reference state
  int m_ticks, m_sub;
  bit m_spent, m_flag;

  always #2.5 clk = ~clk;

  i2c_tmo_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .sif_i(sif), .tmo_en_i(en), .div4_i(div4),
    .irq_en_i(irq_en), .flag_clr_i(clr), .tmo_flag_o(tmo_flag), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks = 0; m_sub = 0; m_spent = 0; m_flag = 0;
    end else begin
      bit hit;
      hit = 0;
      if (!en || sif) begin
        m_ticks = 0; m_sub = 0; m_spent = 0;
      end else if (!m_spent) begin
        if (div4) begin
          m_sub = m_sub + 1;
          if (m_sub == 4) begin m_sub = 0; m_ticks = m_ticks + 1; end
        end else begin
          m_sub = 0; m_ticks = m_ticks + 1;
        end
        if (m_ticks == FULL) begin m_ticks = 0; m_spent = 1; hit = 1; end
      end else begin
        m_sub = 0;
      end
      if (hit) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (tmo_flag !== m_flag || irq !== (m_flag && irq_en)) begin
        miscompares++;
        $display("FAIL %s model: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                 phase, tmo_flag, irq, m_flag, m_flag && irq_en);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_MAX && !done) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_MAX);
      report();
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("R10 flag after reset", tmo_flag, 1'b0);
    chk("R10 irq after reset", irq, 1'b0);

    // R2: disabled, flag level low
    phase = "R2"; sif = 1'b0; en = 1'b0;
    wait_n(300);
    chk("R2 disabled no flag", tmo_flag, 1'b0);

    // R3: enabled but held by flag level high
    phase = "R3"; sif = 1'b1; en = 1'b1;
    wait_n(400);
    chk("R3 held while sif high", tmo_flag, 1'b0);

    // R1: full period at single rate
    phase = "R1"; sif = 1'b0;
    wait_n(FULL - 1);
    chk("R1 flag one edge early", tmo_flag, 1'b0);
    wait_n(1);
    chk("R1 flag at period end", tmo_flag, 1'b1);

    // R6: interrupt gating
    phase = "R6";
    chk("R6 irq masked", irq, 1'b0);
    irq_en = 1'b1;
    #1;
    chk("R6 irq same cycle", irq, 1'b1);
    wait_n(1);

    // R5: sticky then clear
    phase = "R5";
    wait_n(50);
    chk("R5 flag sticky", tmo_flag, 1'b1);
    clr = 1'b1; wait_n(1); clr = 1'b0;
    chk("R5 flag cleared", tmo_flag, 1'b0);
    chk("R6 irq follows clear", irq, 1'b0);

    // R7: one event per stall
    phase = "R7";
    wait_n(FULL + 600);
    chk("R7 no second time-out", tmo_flag, 1'b0);

    // R3: restart after a short flag pulse
    phase = "R3";
    sif = 1'b1; wait_n(1); sif = 1'b0;
    wait_n(10000);
    sif = 1'b1; wait_n(2); sif = 1'b0;
    wait_n(FULL - 1);
    chk("R3 restart full period early", tmo_flag, 1'b0);
    wait_n(1);
    chk("R3 restart full period due", tmo_flag, 1'b1);

    // R8: enable drop keeps the flag, resets the count
    phase = "R8";
    sif = 1'b1; wait_n(1); sif = 1'b0;
    wait_n(10000);
    en = 1'b0; wait_n(3);
    chk("R8 flag kept while disabled", tmo_flag, 1'b1);
    clr = 1'b1; wait_n(1); clr = 1'b0;
    en = 1'b1;
    wait_n(FULL - 1);
    chk("R8 counter restarted", tmo_flag, 1'b0);

    // R9: set and clear on the same edge
    phase = "R9";
    clr = 1'b1; wait_n(1); clr = 1'b0;
    chk("R9 set wins over clear", tmo_flag, 1'b1);
    clr = 1'b1; wait_n(1); clr = 1'b0;

    // R4: divide-by-four period
    phase = "R4";
    sif = 1'b1; div4 = 1'b1; wait_n(1); sif = 1'b0;
    wait_n(4 * FULL - 1);
    chk("R4 slow flag one edge early", tmo_flag, 1'b0);
    wait_n(1);
    chk("R4 slow flag due", tmo_flag, 1'b1);
    wait_n(4);
    report();
  end
endmodule